// File: doc/BRIEF.md
# Stereo First-Order IIR Audio Filter

This block runs a first-order recursive filter on each channel of a stereo audio stream. It suits de-emphasis or simple bass and treble shelving. Each channel carries signed 16-bit samples with its own sample strobe. For every strobed sample the block forms a weighted sum of the new input, the previous input and the previous output. It divides that sum by 2^15 and clamps the result to the 16-bit range. The clamped value appears on the channel output one clock later, together with an output strobe.

The left and right channels each hold an independent set of three signed 16-bit coefficients: a forward weight on the current input, a forward weight on the previous input, and a feedback weight on the previous output. A byte-wide write port loads each coefficient as two 8-bit halves. A coefficient changes only when its upper half is written, so a half-loaded value never reaches the arithmetic. A single enable input selects between the filtered result and a straight pass of the input, and both choices have the same latency.

Top module: `iir1_stereo`

## Requirements
- R1: After reset both outputs are 0 and both output strobes are low. All six coefficients and both channels' history are zero, so an enabled filter produces 0 until coefficients are loaded.
- R2: `leftOutValid` / `rightOutValid` is high in exactly the cycle after the matching input strobe was sampled high. When a channel is not strobed, its output holds its value.
- R3: With the filter enabled, each strobed sample gives y = floor((A·x + B·xPrev + F·yPrev) / 32768). A, B and F are the channel's signed coefficients. xPrev and yPrev are that channel's previous strobed input and previous output. The division is an arithmetic right shift, so it rounds toward minus infinity.
- R4: A filtered result above 32767 is output as 32767. A result below −32768 is output as −32768.
- R5: The two channels use only their own coefficients and history. Strobing one channel leaves the other channel's output unchanged.
- R6: A coefficient write uses address bits as follows. Bit 3 selects the channel (0 = left, 1 = right). Bits 2:1 select the coefficient (0 = A, 1 = B, 2 = F). Bit 0 selects the half (0 = low byte, 1 = high byte). Index 3 is ignored.
- R7: A low-byte write is only staged. The coefficient becomes {high byte, staged low byte} when the high byte is written. A sample strobed in the same cycle as that high-byte write still uses the old value, and later samples use the new one.
- R8: With `filtEn` low, a strobed input appears unchanged on the output, with the same one-cycle latency and strobe behaviour as the filtered path.
- R9: The history always holds the last strobed input and the last emitted output, in both modes. A filtered sample that follows bypassed samples therefore uses the bypassed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| filtEn | input | 1 | 1 = filter, 0 = pass input through |
| coefWe | input | 1 | Coefficient byte write strobe |
| coefAddr | input | 4 | {channel, coefficient index[1:0], half} |
| coefData | input | 8 | Coefficient byte |
| leftIn | input | 16 | Left input sample, signed |
| leftValid | input | 1 | Left sample strobe |
| rightIn | input | 16 | Right input sample, signed |
| rightValid | input | 1 | Right sample strobe |
| leftOut | output | 16 | Left output sample, signed |
| leftOutValid | output | 1 | Left output strobe |
| rightOut | output | 16 | Right output sample, signed |
| rightOutValid | output | 1 | Right output strobe |

## Verification
A pure forward weight on a positive and a negative sample separates correct floor rounding from truncation toward zero. Full-scale inputs with large weights push the sum past both rails and show clamping against wrap-around. Simultaneous and one-sided strobes with different per-channel coefficients reveal any crossover of state between channels. A history carried from bypass into filtering shows whether the state tracks the emitted output. A high-byte write in the same cycle as a strobe, lone low-byte writes and index-3 writes show when coefficients take effect. Long seeded random runs with random coefficients, strobes and enable then exercise the feedback recurrence against a bench model.

// File: rtl/iir1_pkg.sv
package iir1_pkg;

  // Per-channel strobes from control to datapath.
  typedef struct packed {
    logic take;   // sample strobed this cycle
    logic pass;   // send the input straight through
  } chanStrobe_t;

  // Coefficient index carried in the write address.
  typedef enum logic [1:0] {
    COEF_FWD0 = 2'd0,
    COEF_FWD1 = 2'd1,
    COEF_FB   = 2'd2,
    COEF_NONE = 2'd3
  } coefIdx_e;

  localparam int NUM_COEF = 3;

endpackage

// File: rtl/iir1_ctrl.sv
module iir1_ctrl
  import iir1_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int COEF_W = 16
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  logic                                     filtEn,
  input  logic                                     coefWe,
  input  logic [$clog2(NCH)+2:0]                   coefAddr,
  input  logic [COEF_W/2-1:0]                      coefData,
  input  logic [NCH-1:0]                           sampleValid,
  output chanStrobe_t [NCH-1:0]                    strobe,
  output logic [NCH-1:0][NUM_COEF-1:0][COEF_W-1:0] coefs
);

  localparam int HALF_W = COEF_W / 2;
  localparam int CH_W   = $clog2(NCH);
  localparam int ADDR_W = CH_W + 3;

  logic [NCH-1:0][NUM_COEF-1:0][HALF_W-1:0] holdReg;
  logic [CH_W-1:0] chanSel;
  coefIdx_e        coefIdx;
  logic            hiHalf;

  assign chanSel = coefAddr[ADDR_W-1:3];
  assign coefIdx = coefIdx_e'(coefAddr[2:1]);
  assign hiHalf  = coefAddr[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coefs   <= '0;
      holdReg <= '0;
    end else if (coefWe && coefIdx != COEF_NONE) begin
      for (int c = 0; c < NCH; c++) begin
        for (int k = 0; k < NUM_COEF; k++) begin
          if (int'(chanSel) == c && int'(coefIdx) == k) begin
            if (hiHalf) coefs[c][k]   <= {coefData, holdReg[c][k]};
            else        holdReg[c][k] <= coefData;
          end
        end
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_strobe
    assign strobe[c].take = sampleValid[c];
    assign strobe[c].pass = ~filtEn;
  end

endmodule

// File: rtl/iir1_dp.sv
module iir1_dp
  import iir1_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanStrobe_t       strobe,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic [COEF_W-1:0] coefFwd0,
  input  logic [COEF_W-1:0] coefFwd1,
  input  logic [COEF_W-1:0] coefFb,
  output logic [DATA_W-1:0] sampleOut,
  output logic              outValid
);

  localparam int PROD_W = DATA_W + COEF_W;
  localparam int ACC_W  = PROD_W + 2;
  localparam logic signed [ACC_W-1:0] MAXV =
    {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV =
    {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0]        xPrev;
  logic signed [PROD_W-1:0] pCur, pOld, pFb;
  logic signed [ACC_W-1:0]  accSum, accShift;
  logic [DATA_W-1:0]        satVal, nextOut;

  // Previous output doubles as the feedback history.
  assign pCur = $signed(coefFwd0) * $signed(sampleIn);
  assign pOld = $signed(coefFwd1) * $signed(xPrev);
  assign pFb  = $signed(coefFb)   * $signed(sampleOut);

  assign accSum = {{2{pCur[PROD_W-1]}}, pCur}
                + {{2{pOld[PROD_W-1]}}, pOld}
                + {{2{pFb[PROD_W-1]}},  pFb};
  assign accShift = accSum >>> FRAC_W;

  always_comb begin
    if (accShift > MAXV)      satVal = MAXV[DATA_W-1:0];
    else if (accShift < MINV) satVal = MINV[DATA_W-1:0];
    else                      satVal = accShift[DATA_W-1:0];
  end

  assign nextOut = strobe.pass ? sampleIn : satVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleOut <= '0;
      xPrev     <= '0;
      outValid  <= 1'b0;
    end else begin
      outValid <= strobe.take;
      if (strobe.take) begin
        sampleOut <= nextOut;
        xPrev     <= sampleIn;
      end
    end
  end

endmodule

// File: rtl/iir1_stereo.sv
module iir1_stereo
  import iir1_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              filtEn,
  input  logic              coefWe,
  input  logic [3:0]        coefAddr,
  input  logic [COEF_W/2-1:0] coefData,
  input  logic [DATA_W-1:0] leftIn,
  input  logic              leftValid,
  input  logic [DATA_W-1:0] rightIn,
  input  logic              rightValid,
  output logic [DATA_W-1:0] leftOut,
  output logic              leftOutValid,
  output logic [DATA_W-1:0] rightOut,
  output logic              rightOutValid
);

  localparam int NCH = 2;

  chanStrobe_t [NCH-1:0]                    strobe;
  logic [NCH-1:0][NUM_COEF-1:0][COEF_W-1:0] coefs;
  logic [NCH-1:0][DATA_W-1:0]               chIn, chOut;
  logic [NCH-1:0]                           chValid, chOutValid;

  assign chIn    = {rightIn, leftIn};
  assign chValid = {rightValid, leftValid};

  iir1_ctrl #(.NCH(NCH), .COEF_W(COEF_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .filtEn     (filtEn),
    .coefWe     (coefWe),
    .coefAddr   (coefAddr),
    .coefData   (coefData),
    .sampleValid(chValid),
    .strobe     (strobe),
    .coefs      (coefs)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    iir1_dp #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_dp (
      .clk      (clk),
      .rstN     (rstN),
      .strobe   (strobe[c]),
      .sampleIn (chIn[c]),
      .coefFwd0 (coefs[c][0]),
      .coefFwd1 (coefs[c][1]),
      .coefFb   (coefs[c][2]),
      .sampleOut(chOut[c]),
      .outValid (chOutValid[c])
    );
  end

  assign leftOut       = chOut[0];
  assign rightOut      = chOut[1];
  assign leftOutValid  = chOutValid[0];
  assign rightOutValid = chOutValid[1];

endmodule

// File: rtl/iir1_chk.sv
module iir1_chk #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              filtEn,
  input logic              coefWe,
  input logic [3:0]        coefAddr,
  input logic [COEF_W/2-1:0] coefData,
  input logic [DATA_W-1:0] leftIn,
  input logic              leftValid,
  input logic [DATA_W-1:0] rightIn,
  input logic              rightValid,
  input logic [DATA_W-1:0] leftOut,
  input logic              leftOutValid,
  input logic [DATA_W-1:0] rightOut,
  input logic              rightOutValid
);

  a_r2_left_strobe: assert property (@(posedge clk) disable iff (!rstN)
    leftValid |=> leftOutValid);
  a_r2_right_strobe: assert property (@(posedge clk) disable iff (!rstN)
    rightValid |=> rightOutValid);

  // R2 and R5: an unstrobed channel is quiet and holds its value.
  a_r5_left_hold: assert property (@(posedge clk) disable iff (!rstN)
    !leftValid |=> (!leftOutValid && $stable(leftOut)));
  a_r5_right_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rightValid |=> (!rightOutValid && $stable(rightOut)));

  a_r8_left_pass: assert property (@(posedge clk) disable iff (!rstN)
    (leftValid && !filtEn) |=> leftOut == $past(leftIn));
  a_r8_right_pass: assert property (@(posedge clk) disable iff (!rstN)
    (rightValid && !filtEn) |=> rightOut == $past(rightIn));

endmodule

bind iir1_stereo iir1_chk #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_chk (.*);

// File: tb/iir1_stereo_bench.sv
`timescale 1ns/1ps
module iir1_stereo_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        filtEn = 1'b1;
  logic        coefWe = 1'b0;
  logic [3:0]  coefAddr = '0;
  logic [7:0]  coefData = '0;
  logic [15:0] leftIn = '0, rightIn = '0;
  logic        leftValid = 1'b0, rightValid = 1'b0;
  logic [15:0] leftOut, rightOut;
  logic        leftOutValid, rightOutValid;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Model state
  int mCoef [2][3];
  int mHold [2][3];
  int mX [2];
  int mY [2];

  always #2.5 clk = ~clk;

  iir1_stereo u_iir1_stereo (
    .clk(clk), .rstN(rstN), .filtEn(filtEn), .coefWe(coefWe),
    .coefAddr(coefAddr), .coefData(coefData),
    .leftIn(leftIn), .leftValid(leftValid),
    .rightIn(rightIn), .rightValid(rightValid),
    .leftOut(leftOut), .leftOutValid(leftOutValid),
    .rightOut(rightOut), .rightOutValid(rightOutValid)
  );

  function automatic int s16(input int v);
    return int'($signed(16'(v)));
  endfunction

  function automatic int fexp(input int a, input int b, input int f,
                              input int x, input int xp, input int yp);
    longint acc;
    acc = longint'(a) * x + longint'(b) * xp + longint'(f) * yp;
    acc = acc >>> 15;
    if (acc > 32767)  acc = 32767;
    if (acc < -32768) acc = -32768;
    return int'(acc);
  endfunction

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  // One cycle: optional coefficient byte write plus optional strobes.
  task automatic step(input bit wr, input int ch, input int idx, input int half,
                      input int data, input bit en,
                      input bit lv, input int lx, input bit rv, input int rx,
                      input string req);
    int expY [2];
    bit v [2];
    int x [2];
    @(negedge clk);
    filtEn = en;
    coefWe = wr;
    coefAddr = 4'((ch << 3) | (idx << 1) | half);
    coefData = 8'(data);
    leftValid = lv;  leftIn = 16'(lx);
    rightValid = rv; rightIn = 16'(rx);
    v[0] = lv; v[1] = rv; x[0] = s16(lx); x[1] = s16(rx);
    for (int c = 0; c < 2; c++) begin
      if (!v[c]) expY[c] = mY[c];
      else if (!en) expY[c] = x[c];
      else expY[c] = fexp(mCoef[c][0], mCoef[c][1], mCoef[c][2], x[c], mX[c], mY[c]);
    end
    @(negedge clk);
    coefWe = 1'b0; leftValid = 1'b0; rightValid = 1'b0;
    check(req, "left valid",  int'(leftOutValid),  int'(lv));
    check(req, "right valid", int'(rightOutValid), int'(rv));
    check(req, "left out",  int'($signed(leftOut)),  expY[0]);
    check(req, "right out", int'($signed(rightOut)), expY[1]);
    for (int c = 0; c < 2; c++) begin
      if (v[c]) begin mX[c] = x[c]; mY[c] = expY[c]; end
    end
    if (wr && idx != 3) begin
      if (half == 0) mHold[ch][idx] = data & 8'hFF;
      else mCoef[ch][idx] = s16(((data & 8'hFF) << 8) | mHold[ch][idx]);
    end
  endtask

  task automatic wrCoef(input int ch, input int idx, input int val, input string req);
    step(1'b1, ch, idx, 0, val & 8'hFF, filtEn, 1'b0, 0, 1'b0, 0, req);
    step(1'b1, ch, idx, 1, (val >> 8) & 8'hFF, filtEn, 1'b0, 0, 1'b0, 0, req);
  endtask

  task automatic smp(input bit lv, input int lx, input bit rv, input int rx,
                     input string req);
    step(1'b0, 0, 0, 0, 0, filtEn, lv, lx, rv, rx, req);
  endtask

  initial begin
    int cycles = 0;
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nFails++;
        nChecks++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
        summary();
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd61357));
    for (int c = 0; c < 2; c++) begin
      mX[c] = 0; mY[c] = 0;
      for (int k = 0; k < 3; k++) begin mCoef[c][k] = 0; mHold[c][k] = 0; end
    end
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", "left out reset",  int'(leftOut), 0);
    check("R1", "right out reset", int'(rightOut), 0);
    check("R1", "valid reset", int'(leftOutValid | rightOutValid), 0);
    rstN = 1'b1;
    // R1: zero coefficients give zero
    smp(1'b1, 1000, 1'b1, -2000, "R1");

    // R7: lone low-byte write is staged only
    step(1'b1, 0, 0, 0, 8'h00, 1'b1, 1'b0, 0, 1'b0, 0, "R7");
    smp(1'b1, 1200, 1'b0, 0, "R7");
    // R3: half-scale forward weight, positive then negative (floor)
    step(1'b1, 0, 0, 1, 8'h40, 1'b1, 1'b0, 0, 1'b0, 0, "R6");
    smp(1'b1, 1000, 1'b0, 0, "R3");
    smp(1'b1, -3, 1'b0, 0, "R3");
    check("R3", "floor of -1.5", mY[0], -2);

    // R4: saturation at both rails
    wrCoef(0, 0, 16'h7FFF, "R4");
    wrCoef(0, 1, 16'h7FFF, "R4");
    smp(1'b1, 32767, 1'b0, 0, "R4");
    smp(1'b1, 32767, 1'b0, 0, "R4");
    check("R4", "upper rail", mY[0], 32767);
    smp(1'b1, -32768, 1'b0, 0, "R4");
    smp(1'b1, -32768, 1'b0, 0, "R4");
    check("R4", "lower rail", mY[0], -32768);

    // R5: independent right channel with feedback
    wrCoef(1, 0, 16'h2000, "R5");
    wrCoef(1, 2, 16'h6000, "R5");
    smp(1'b1, 500, 1'b1, 8000, "R5");
    smp(1'b0, 0, 1'b1, 8000, "R5");
    smp(1'b1, -700, 1'b0, 0, "R5");

    // R6: index 3 writes ignored
    step(1'b1, 1, 3, 0, 8'hFF, 1'b1, 1'b0, 0, 1'b0, 0, "R6");
    step(1'b1, 1, 3, 1, 8'h7F, 1'b1, 1'b0, 0, 1'b0, 0, "R6");
    smp(1'b0, 0, 1'b1, 4000, "R6");

    // R8 and R9: bypass, then filter from bypassed history
    wrCoef(0, 0, 16'h4000, "R9");
    wrCoef(0, 1, 16'h2000, "R9");
    wrCoef(0, 2, 16'h1000, "R9");
    step(1'b0, 0, 0, 0, 0, 1'b0, 1'b1, 12345, 1'b1, -321, "R8");
    step(1'b0, 0, 0, 0, 0, 1'b0, 1'b1, -20000, 1'b0, 0, "R8");
    step(1'b0, 0, 0, 0, 0, 1'b1, 1'b1, 800, 1'b1, 100, "R9");

    // R7: high-byte write in the same cycle as a strobe uses the old value
    step(1'b1, 0, 0, 0, 8'h00, 1'b1, 1'b0, 0, 1'b0, 0, "R7");
    step(1'b1, 0, 0, 1, 8'hC0, 1'b1, 1'b1, 6000, 1'b0, 0, "R7");
    smp(1'b1, 6000, 1'b0, 0, "R7");

    // Random mix of R2, R3, R5, R8, R9
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 9) == 0)
        wrCoef($urandom_range(0, 1), $urandom_range(0, 2), $urandom(), "R3");
      step(1'b0, 0, 0, 0, 0, ($urandom_range(0, 7) != 0),
           $urandom_range(0, 1), int'($urandom()),
           $urandom_range(0, 1), int'($urandom()), "R2");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule